// File: doc/BRIEF.md
# Segment Line Store with Automatic Self-Refresh

This block holds a whole display frame of segment lines in an internal line memory and drives the column drive-level codes from it, one line per latch pulse. The host side delivers a captured 80-bit line, a one-cycle indication whenever a shift-clock edge was seen, a latch pulse, a frame-start flag, the AC polarity level and an active-high display-enable. All of these are synchronous to `clk`. The block detects the falling edge of the latch pulse itself.

On every latch fall the row at the current address is copied into the output pixel latch. In the same cycle the captured line is taken into a write register. One cycle later that register is written back into the same row, but only if shift-clock activity was seen during the line period that just closed. The row address then advances. A line period with no activity therefore leaves memory untouched while the display keeps being refreshed from it. Writing resumes on its own once activity returns.

The frame length is set by how many latch pulses fall between frame-start flags. With frame-start low throughout, the address wraps from the last row to row 0. Each segment output is a 2-bit level code built from the latched pixel, the live AC polarity and the display-enable.

Top module: `line_store_ctrl`

## Requirements
- R1: After reset the pixel latch is all clear. With `disp_en` low every code is 0. With `disp_en` high and `ac_pol` low every code is 1.
- R2: A latch fall (`latch_pulse` high in one cycle, low in the next) loads the pixel latch from the addressed row as it stood before any write triggered by that same fall.
- R3: If at least one `shift_seen` pulse arrived in the line period ending at a latch fall, `line_in` sampled in the fall cycle is stored into the row addressed at that fall.
- R4: If no `shift_seen` pulse arrived in that line period, the addressed row keeps its contents, and the row address still advances by one.
- R5: If `frame_start` is high in the fall cycle, row 0 is read (and written, per R3) and the next row is 1.
- R6: With `frame_start` low, the row after row NROW-1 (199) is row 0.
- R7: After one or more line periods without activity, the first line period with activity again has its line stored at the closing fall.
- R8: While `disp_en` is low every code is 0, and memory contents are kept. Rows read after re-enabling show the data stored before.
- R9: Level codes with display enabled: set pixel with `ac_pol`=1 gives 3, set pixel with `ac_pol`=0 gives 0, clear pixel with `ac_pol`=1 gives 2, clear pixel with `ac_pol`=0 gives 1. Segment i shows bit i of the row.
- R10: A change of `ac_pol` or `disp_en` changes the codes in the same cycle, without waiting for a latch fall.
- R11: A `shift_seen` pulse in the fall cycle itself counts toward the line period that this fall opens, not the one it closes.
- R12: Between latch falls, with `ac_pol` and `disp_en` steady, the codes hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | NSEG (80) | Captured line from the input capture stage |
| shift_seen | input | 1 | Pulse: a shift-clock edge occurred this cycle |
| latch_pulse | input | 1 | Line latch pulse level; its fall advances one line |
| frame_start | input | 1 | Frame-start flag sampled at the latch fall |
| ac_pol | input | 1 | AC drive polarity, applied combinationally |
| disp_en | input | 1 | Display enable; low forces every code to 0 |
| seg_code | output | NSEG x 2 | Per-segment level code (0,1,2,3 per R9) |

## Verification
Two functions can land in the same clock cycle. A shift-clock pulse can coincide with a latch fall. A frame-start flag can coincide with a fall that also ends an active line, so the row-0 reset, the read and the write-back decision all resolve on one edge. The bench provokes the first case by raising `shift_seen` only in the fall cycle, so the closing line is treated as self-refresh. The following line then carries no pulse of its own, yet its data must appear in memory when that row is read in the next frame. Frame-start falls with active lines are judged by reading row 0 in the next frame and by the row that follows it.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    // 2-bit drive-level codes, from the level nearest the supply down
    typedef enum logic [1:0] {
        LVL_TOP   = 2'd0,
        LVL_UPPER = 2'd1,
        LVL_LOWER = 2'd2,
        LVL_BOT   = 2'd3
    } lvl_t;

    function automatic lvl_t pick_level(input logic pix, input logic pol, input logic en);
        if (!en)
            return LVL_TOP;
        if (pix)
            return pol ? LVL_BOT : LVL_TOP;
        return pol ? LVL_LOWER : LVL_UPPER;
    endfunction

endpackage

// File: rtl/lsc_line_mem.sv
module lsc_line_mem #(
    parameter int NSEG = 80,
    parameter int NROW = 200,
    localparam int AW  = $clog2(NROW)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [NSEG-1:0] wdata,
    input  logic [AW-1:0]   raddr,
    output logic [NSEG-1:0] rdata
);

    logic [NSEG-1:0] rows [NROW];

    always_ff @(posedge clk) begin
        if (we)
            rows[waddr] <= wdata;
    end

    assign rdata = rows[raddr];

endmodule

// File: rtl/lsc_seq.sv
module lsc_seq #(
    parameter int NSEG = 80,
    parameter int NROW = 200,
    localparam int AW  = $clog2(NROW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            latch_pulse,
    input  logic            frame_start,
    input  logic            shift_seen,
    input  logic [NSEG-1:0] line_in,
    output logic            fall,
    output logic [AW-1:0]   rd_addr,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [NSEG-1:0] wr_data,
    output logic [AW-1:0]   row
);

    localparam logic [AW-1:0] LAST_ROW = AW'(NROW - 1);

    typedef struct packed {
        logic            lat;
        logic            act;
        logic            wpend;
        logic [AW-1:0]   row;
        logic [AW-1:0]   waddr;
        logic [NSEG-1:0] wreg;
    } seq_t;

    seq_t          st_d, st_q;
    logic [AW-1:0] addr_d;

    always_comb begin
        st_d     = st_q;
        fall     = st_q.lat & ~latch_pulse;
        addr_d   = frame_start ? '0 : st_q.row;
        st_d.lat = latch_pulse;
        // a pulse in the fall cycle belongs to the period being opened
        st_d.act   = fall ? shift_seen : (st_q.act | shift_seen);
        st_d.wpend = fall & st_q.act;
        if (fall) begin
            st_d.waddr = addr_d;
            st_d.wreg  = line_in;
            st_d.row   = (addr_d == LAST_ROW) ? '0 : addr_d + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rd_addr = addr_d;
    assign wr_en   = st_q.wpend;
    assign wr_addr = st_q.waddr;
    assign wr_data = st_q.wreg;
    assign row     = st_q.row;

endmodule

// File: rtl/lsc_drive.sv
module lsc_drive
    import lsc_pkg::*;
#(
    parameter int NSEG = 80
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [NSEG-1:0]      rd_data,
    input  logic                 ac_pol,
    input  logic                 disp_en,
    output logic [NSEG-1:0][1:0] seg_code
);

    logic [NSEG-1:0] pix_d, pix_q;

    always_comb begin
        pix_d = load ? rd_data : pix_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pix_q <= '0;
        else
            pix_q <= pix_d;
    end

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        always_comb begin
            seg_code[i] = pick_level(pix_q[i], ac_pol, disp_en);
        end
    end

endmodule

// File: rtl/line_store_ctrl.sv
module line_store_ctrl #(
    parameter int NSEG = 80,
    parameter int NROW = 200
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSEG-1:0]      line_in,
    input  logic                 shift_seen,
    input  logic                 latch_pulse,
    input  logic                 frame_start,
    input  logic                 ac_pol,
    input  logic                 disp_en,
    output logic [NSEG-1:0][1:0] seg_code
);

    localparam int AW = $clog2(NROW);

    logic            fall_w;
    logic [AW-1:0]   rd_addr_w;
    logic            wr_en_w;
    logic [AW-1:0]   wr_addr_w;
    logic [NSEG-1:0] wr_data_w;
    logic [AW-1:0]   row_w;
    logic [NSEG-1:0] rd_data_w;

    lsc_seq #(.NSEG(NSEG), .NROW(NROW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .latch_pulse (latch_pulse),
        .frame_start (frame_start),
        .shift_seen  (shift_seen),
        .line_in     (line_in),
        .fall        (fall_w),
        .rd_addr     (rd_addr_w),
        .wr_en       (wr_en_w),
        .wr_addr     (wr_addr_w),
        .wr_data     (wr_data_w),
        .row         (row_w)
    );

    lsc_line_mem #(.NSEG(NSEG), .NROW(NROW)) u_mem (
        .clk   (clk),
        .we    (wr_en_w),
        .waddr (wr_addr_w),
        .wdata (wr_data_w),
        .raddr (rd_addr_w),
        .rdata (rd_data_w)
    );

    lsc_drive #(.NSEG(NSEG)) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fall_w),
        .rd_data  (rd_data_w),
        .ac_pol   (ac_pol),
        .disp_en  (disp_en),
        .seg_code (seg_code)
    );

endmodule

// File: rtl/lsc_chk.sv
module lsc_chk #(
    parameter int NSEG = 80,
    parameter int NROW = 200,
    localparam int AW  = $clog2(NROW)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 latch_pulse,
    input  logic                 frame_start,
    input  logic                 ac_pol,
    input  logic                 disp_en,
    input  logic [NSEG-1:0][1:0] seg_code,
    input  logic [AW-1:0]        row,
    input  logic                 wr_en
);

    logic lp_prev;
    logic fell;

    always_ff @(posedge clk) begin
        if (!rst_n)
            lp_prev <= 1'b0;
        else
            lp_prev <= latch_pulse;
    end

    assign fell = lp_prev & ~latch_pulse;

    AST_BLANK_ALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |-> (seg_code == '0)); // R8

    AST_HOLD_BETWEEN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !fell ##1 ($stable(ac_pol) && $stable(disp_en)) |-> $stable(seg_code)); // R12

    AST_FRAME_START_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (fell && frame_start) |=> (row == AW'(1))); // R5

    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (fell && !frame_start && row == AW'(NROW - 1)) |=> (row == '0)); // R6

    AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        row < AW'(NROW)); // R6

    AST_WRITE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(fell)); // R3

endmodule

bind line_store_ctrl lsc_chk #(.NSEG(NSEG), .NROW(NROW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .latch_pulse (latch_pulse),
    .frame_start (frame_start),
    .ac_pol      (ac_pol),
    .disp_en     (disp_en),
    .seg_code    (seg_code),
    .row         (row_w),
    .wr_en       (wr_en_w)
);

// File: tb/sim_line_store_ctrl.sv
`timescale 1ns/1ps
module sim_line_store_ctrl;

    localparam int NSEG = 80;
    localparam int NROW = 200;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NSEG-1:0]      line_in = '0;
    logic                 shift_seen = 1'b0;
    logic                 latch_pulse = 1'b0;
    logic                 frame_start = 1'b0;
    logic                 ac_pol = 1'b0;
    logic                 disp_en = 1'b0;
    logic [NSEG-1:0][1:0] seg_code;

    always #2 clk = ~clk;

    line_store_ctrl #(.NSEG(NSEG), .NROW(NROW)) u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .shift_seen(shift_seen),
        .latch_pulse(latch_pulse), .frame_start(frame_start),
        .ac_pol(ac_pol), .disp_en(disp_en), .seg_code(seg_code)
    );

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // reference model of the line store
    logic [NSEG-1:0] m_mem   [NROW];
    logic            m_known [NROW];
    int              m_row   = 0;
    logic            m_carry = 1'b0;

    // scoreboard: {known, expected row contents}
    logic [NSEG:0]   sb_q [$];
    logic [NSEG-1:0] shown_vec = '0;
    logic            shown_ok  = 1'b1;

    function automatic logic [1:0] lvl(input logic b, input logic a, input logic en);
        if (!en) return 2'd0;
        if (b)   return a ? 2'd3 : 2'd0;
        return a ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [NSEG-1:0] pat(input int seed, input int r);
        logic [15:0] w;
        w = 16'(seed * 40503 + r * 9157 + 4321);
        return {w, ~w, {w[7:0], w[15:8]}, w ^ 16'h5A3C, 16'(r)};
    endfunction

    task automatic check_vec(input string req, input logic [NSEG-1:0] v);
        logic [NSEG-1:0][1:0] exp_c;
        for (int i = 0; i < NSEG; i++) exp_c[i] = lvl(v[i], ac_pol, disp_en);
        n_chk++;
        if (seg_code !== exp_c) begin
            n_bad++;
            $display("FAIL %s seg_code got=%h exp=%h", req, seg_code, exp_c);
        end
    endtask

    // driver: one line period, pushes the expected read into the scoreboard
    task automatic do_line(input logic [NSEG-1:0] data, input logic act,
                           input logic fs, input logic carry);
        int addr;
        logic wr;
        @(negedge clk);
        line_in = data;
        shift_seen = act;
        @(negedge clk);
        shift_seen = 1'b0;
        latch_pulse = 1'b1;
        frame_start = fs;
        @(negedge clk);
        latch_pulse = 1'b0;
        shift_seen = carry;
        addr = fs ? 0 : m_row;
        sb_q.push_back({m_known[addr], m_mem[addr]});
        wr = m_carry | act;
        if (wr) begin
            m_mem[addr]   = data;
            m_known[addr] = 1'b1;
        end
        m_row   = (addr == NROW - 1) ? 0 : addr + 1;
        m_carry = carry;
        @(negedge clk);
        frame_start = 1'b0;
        shift_seen = 1'b0;
        @(negedge clk);
    endtask

    task automatic frame(input int seed, input logic [3:0] act_mask);
        for (int r = 0; r < 4; r++) do_line(pat(seed, r), act_mask[r], r == 0, 1'b0);
    endtask

    // monitor: one line result one cycle after each observed latch fall
    initial begin
        logic lp_prev;
        logic [NSEG:0] item;
        lp_prev = 1'b0;
        forever begin
            @(posedge clk);
            if (lp_prev && !latch_pulse && rst_n) begin
                @(negedge clk);
                #1;
                if (sb_q.size() == 0) begin
                    n_chk++;
                    n_bad++;
                    $display("FAIL %s unexpected line got=%h exp=none", cur_req, seg_code);
                end else begin
                    item = sb_q.pop_front();
                    shown_ok  = item[NSEG];
                    shown_vec = item[NSEG-1:0];
                    if (shown_ok) check_vec(cur_req, shown_vec);
                end
                lp_prev = latch_pulse;
            end else begin
                lp_prev = latch_pulse;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog got=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NROW; i++) begin
            m_known[i] = 1'b0;
            m_mem[i]   = '0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check_vec("R1", '0);          // display off: all codes 0
        disp_en = 1'b1;
        #1;
        check_vec("R1", '0);          // clear pixels, polarity low: all codes 1

        // R3: fill a 4-row frame, then read it back while writing new data
        cur_req = "R3";
        frame(1, 4'hF);
        cur_req = "R2";               // reads show the old row, not the line written now
        frame(2, 4'hF);

        // R4: self-refresh, reads keep showing the last stored frame
        cur_req = "R4";
        frame(3, 4'h0);
        frame(4, 4'h0);

        // R7: activity returns on row 0 only
        cur_req = "R7";
        frame(5, 4'b0001);
        frame(6, 4'h0);

        // R5: frame start arriving after two lines returns to row 0
        cur_req = "R5";
        do_line(pat(7, 0), 1'b0, 1'b1, 1'b0);
        do_line(pat(7, 1), 1'b0, 1'b0, 1'b0);
        do_line(pat(7, 2), 1'b0, 1'b1, 1'b0);
        do_line(pat(7, 3), 1'b0, 1'b0, 1'b0);

        // R11: pulse only in the fall cycle: row 0 not written, row 1 written
        cur_req = "R11";
        do_line(pat(8, 0), 1'b0, 1'b1, 1'b1);
        do_line(pat(8, 1), 1'b0, 1'b0, 1'b0);
        frame(9, 4'h0);

        // R9 / R10: polarity applied at once to the shown line
        @(negedge clk);
        ac_pol = 1'b1;
        #1;
        check_vec("R10", shown_vec);
        check_vec("R9", shown_vec);
        @(negedge clk);
        ac_pol = 1'b0;
        #1;
        check_vec("R9", shown_vec);

        // R12: outputs hold between falls
        repeat (3) @(negedge clk);
        #1;
        check_vec("R12", shown_vec);

        // R8: display off forces 0, memory kept
        cur_req = "R8";
        @(negedge clk);
        disp_en = 1'b0;
        #1;
        check_vec("R8", '0);
        frame(10, 4'h0);
        @(negedge clk);
        disp_en = 1'b1;
        ac_pol = 1'b1;
        frame(11, 4'h0);
        ac_pol = 1'b0;

        // R6: full 200-row pass, then one more line wraps to row 0
        cur_req = "R6";
        for (int r = 0; r < NROW; r++) do_line(pat(20, r), 1'b1, r == 0, 1'b0);
        do_line(pat(21, 0), 1'b0, 1'b0, 1'b0);
        do_line(pat(21, 1), 1'b0, 1'b0, 1'b0);

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 pending lines got=%0d exp=0", sb_q.size());
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule